// File: doc/BRIEF.md
# Interrupt Source Configuration Table

This block keeps a small configuration record for every interrupt source owned by one source unit. Each record holds the destination server, the current priority and a saved priority. A single-cycle command port carries one of four operations: set, get, disable and enable. Each command is addressed by a global interrupt number. The block translates that number to a local table index by subtracting a base offset, and it checks the request before acting on it. One cycle later it returns a status code and, for a successful get, the record's contents.

Disable masks a source without losing its configuration. It forces the current priority to the least-favoured value, 0xFF, and moves the old current priority into the saved field. Enable then restores the current priority from that saved copy. A build parameter can remove the source unit altogether. In that variant the table is left out, and every well-formed command is answered with a hardware error.

Top module: `intsrc_cfg_table`

## Requirements
- R1: A global number N selects an entry only when SRC_OFFSET <= N < SRC_OFFSET + NUM_SRC. The entry it selects is local index N - SRC_OFFSET. A well-formed command that names any other number gets status 1 (parameter error) and changes no entry.
- R2: An accepted set writes the server and the priority. It also writes the same priority into the saved field.
- R3: A set whose server is >= NUM_SERVERS, or whose priority is greater than 0xFF, gets status 1 and leaves the entry unchanged.
- R4: Disable keeps the server and sets the current priority to 0xFF. It loads the saved priority with the current priority held before the command. A second disable therefore saves 0xFF.
- R5: Enable keeps the server and sets both the current and the saved priority to the stored saved priority.
- R6: A successful get returns status 0 with rsp_nres = 3, together with the entry's server and current priority. A get that fails returns its status with rsp_nres = 1, and rsp_server and rsp_prio read 0.
- R7: With SRC_PRESENT = 0, every command with correct arity gets status 2 (hardware error).
- R8: Each operation has a fixed arity (argument count / result count). Set is 3/1, get is 1/3, disable and enable are 1/1. A command whose counts do not match its operation gets status 1, and this check takes precedence over the hardware error.
- R9: Status codes are 0 success, 1 parameter error and 2 hardware error. Operation codes on req_op are 0 set, 1 get, 2 disable and 3 enable. rsp_valid pulses exactly one cycle after each req_valid cycle and at no other time, so back-to-back commands are allowed.
- R10: After reset every entry holds server 0, current priority 0xFF and saved priority 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command present this cycle |
| req_op | input | 2 | Operation code (R9) |
| req_nargs | input | 4 | Argument count supplied with the command |
| req_nret | input | 4 | Result count expected by the caller |
| req_irq | input | 32 | Global interrupt number |
| req_server | input | 32 | Server number for set |
| req_prio | input | 32 | Priority for set |
| rsp_valid | output | 1 | Response pulse |
| rsp_status | output | 2 | Status code |
| rsp_nres | output | 2 | Number of valid result words (1 or 3) |
| rsp_server | output | 32 | Server returned by get |
| rsp_prio | output | 8 | Current priority returned by get |

## Verification
The bound checker watches several properties on every cycle:
- the one-cycle response timing and the legality of the status code;
- the short form of every failed response;
- rejection of mismatched get arity, of out-of-range priorities and of numbers above the window;
- the hardware error in the variant without a source unit.

Only the bench's scenarios can show the stored-state behaviour. This covers set writing the saved copy, disable and enable moving priorities between fields (including a double disable), entries left untouched after rejected commands, and the reset contents. The bench shows these by reading entries back with get and comparing against a behavioural model.

// File: rtl/intsrc_cfg_pkg.sv
package intsrc_cfg_pkg;

   typedef enum logic [1:0] {
      OP_SET = 2'd0,
      OP_GET = 2'd1,
      OP_OFF = 2'd2,
      OP_ON  = 2'd3
   } cfg_op_e;

   typedef enum logic [1:0] {
      ST_OK    = 2'd0,
      ST_PARAM = 2'd1,
      ST_HW    = 2'd2
   } cfg_status_e;

   localparam int unsigned SET_NARGS = 3;
   localparam int unsigned SET_NRET  = 1;
   localparam int unsigned GET_NARGS = 1;
   localparam int unsigned GET_NRET  = 3;
   localparam int unsigned MSK_NARGS = 1;
   localparam int unsigned MSK_NRET  = 1;

endpackage

// File: rtl/intsrc_req_decode.sv
module intsrc_req_decode
   import intsrc_cfg_pkg::*;
#(
   parameter int unsigned IRQ_W       = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned CNT_W       = 4,
   parameter int unsigned PRIO_W      = 8,
   parameter int unsigned NUM_SRC     = 16,
   parameter int unsigned SRC_OFFSET  = 4096,
   parameter int unsigned NUM_SERVERS = 4,
   parameter bit          SRC_PRESENT = 1'b1,
   parameter int unsigned IDX_W       = 4
) (
   input  cfg_op_e            op,
   input  logic [CNT_W-1:0]   nargs,
   input  logic [CNT_W-1:0]   nret,
   input  logic [IRQ_W-1:0]   irq,
   input  logic [DATA_W-1:0]  server,
   input  logic [DATA_W-1:0]  prio,
   output cfg_status_e        status,
   output logic [IDX_W-1:0]   idx
);

   localparam logic [IRQ_W:0]  WIN_LO   = (IRQ_W+1)'(64'(SRC_OFFSET));
   localparam logic [IRQ_W:0]  WIN_HI   = (IRQ_W+1)'(64'(SRC_OFFSET) + 64'(NUM_SRC));
   localparam logic [DATA_W:0] SRV_LIM  = (DATA_W+1)'(NUM_SERVERS);
   localparam logic [DATA_W-1:0] PRIO_MAX = DATA_W'((64'd1 << PRIO_W) - 64'd1);

   logic              arity_ok;
   logic              in_window;
   logic              set_args_ok;
   logic [IRQ_W-1:0]  local_num;

   always_comb begin
      unique case (op)
         OP_SET:  arity_ok = (nargs == CNT_W'(SET_NARGS)) && (nret == CNT_W'(SET_NRET));
         OP_GET:  arity_ok = (nargs == CNT_W'(GET_NARGS)) && (nret == CNT_W'(GET_NRET));
         default: arity_ok = (nargs == CNT_W'(MSK_NARGS)) && (nret == CNT_W'(MSK_NRET));
      endcase
   end

   assign in_window   = ({1'b0, irq} >= WIN_LO) && ({1'b0, irq} < WIN_HI);
   assign set_args_ok = ({1'b0, server} < SRV_LIM) && (prio <= PRIO_MAX);
   assign local_num   = irq - IRQ_W'(SRC_OFFSET);
   assign idx         = local_num[IDX_W-1:0];

   always_comb begin
      if (!arity_ok)                         status = ST_PARAM;
      else if (!SRC_PRESENT)                 status = ST_HW;
      else if (!in_window)                   status = ST_PARAM;
      else if (op == OP_SET && !set_args_ok) status = ST_PARAM;
      else                                   status = ST_OK;
   end

endmodule

// File: rtl/intsrc_cfg_store.sv
module intsrc_cfg_store
   import intsrc_cfg_pkg::*;
#(
   parameter int unsigned NUM_SRC = 16,
   parameter int unsigned IDX_W   = 4,
   parameter int unsigned SRV_W   = 2,
   parameter int unsigned PRIO_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  cfg_op_e           wr_op,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [SRV_W-1:0]  wr_server,
   input  logic [PRIO_W-1:0] wr_prio,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [SRV_W-1:0]  rd_server,
   output logic [PRIO_W-1:0] rd_prio
);

   localparam logic [PRIO_W-1:0] PRIO_MASKED = '1;

   logic [SRV_W-1:0]  srv_q [NUM_SRC];
   logic [PRIO_W-1:0] cur_q [NUM_SRC];
   logic [PRIO_W-1:0] sav_q [NUM_SRC];

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_entry
      logic hit;
      assign hit = wr_en && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            srv_q[g] <= '0;
            cur_q[g] <= PRIO_MASKED;
            sav_q[g] <= PRIO_MASKED;
         end else if (hit) begin
            unique case (wr_op)
               OP_SET: begin
                  srv_q[g] <= wr_server;
                  cur_q[g] <= wr_prio;
                  sav_q[g] <= wr_prio;
               end
               OP_OFF: begin
                  cur_q[g] <= PRIO_MASKED;
                  sav_q[g] <= cur_q[g];
               end
               OP_ON: begin
                  cur_q[g] <= sav_q[g];
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      rd_server = '0;
      rd_prio   = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (rd_idx == IDX_W'(i)) begin
            rd_server = srv_q[i];
            rd_prio   = cur_q[i];
         end
      end
   end

endmodule

// File: rtl/intsrc_cfg_table.sv
module intsrc_cfg_table
   import intsrc_cfg_pkg::*;
#(
   parameter int unsigned IRQ_W       = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned CNT_W       = 4,
   parameter int unsigned PRIO_W      = 8,
   parameter int unsigned NUM_SRC     = 16,
   parameter int unsigned SRC_OFFSET  = 4096,
   parameter int unsigned NUM_SERVERS = 4,
   parameter bit          SRC_PRESENT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [CNT_W-1:0]  req_nargs,
   input  logic [CNT_W-1:0]  req_nret,
   input  logic [IRQ_W-1:0]  req_irq,
   input  logic [DATA_W-1:0] req_server,
   input  logic [DATA_W-1:0] req_prio,
   output logic              rsp_valid,
   output logic [1:0]        rsp_status,
   output logic [1:0]        rsp_nres,
   output logic [DATA_W-1:0] rsp_server,
   output logic [PRIO_W-1:0] rsp_prio
);

   localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam int unsigned SRV_W = (NUM_SERVERS > 1) ? $clog2(NUM_SERVERS) : 1;

   if (NUM_SRC < 1)       begin : g_bad_src  $error("NUM_SRC must be at least 1");        end
   if (NUM_SERVERS < 1)   begin : g_bad_srv  $error("NUM_SERVERS must be at least 1");    end
   if (DATA_W <= PRIO_W)  begin : g_bad_prio $error("DATA_W must exceed PRIO_W");         end
   if (DATA_W < SRV_W)    begin : g_bad_dat  $error("DATA_W too narrow for servers");     end
   if (CNT_W < 2)         begin : g_bad_cnt  $error("CNT_W must hold the arity values");  end
   if (IRQ_W < IDX_W)     begin : g_bad_irq  $error("IRQ_W too narrow for the table");    end

   cfg_op_e           op;
   cfg_status_e       status;
   logic [IDX_W-1:0]  idx;
   logic [SRV_W-1:0]  rd_server;
   logic [PRIO_W-1:0] rd_prio;
   logic              get_ok;

   assign op = cfg_op_e'(req_op);

   intsrc_req_decode #(
      .IRQ_W       (IRQ_W),
      .DATA_W      (DATA_W),
      .CNT_W       (CNT_W),
      .PRIO_W      (PRIO_W),
      .NUM_SRC     (NUM_SRC),
      .SRC_OFFSET  (SRC_OFFSET),
      .NUM_SERVERS (NUM_SERVERS),
      .SRC_PRESENT (SRC_PRESENT),
      .IDX_W       (IDX_W)
   ) u_decode (
      .op     (op),
      .nargs  (req_nargs),
      .nret   (req_nret),
      .irq    (req_irq),
      .server (req_server),
      .prio   (req_prio),
      .status (status),
      .idx    (idx)
   );

   if (SRC_PRESENT) begin : g_unit
      logic wr_en;
      assign wr_en = req_valid && (status == ST_OK) && (op != OP_GET);

      intsrc_cfg_store #(
         .NUM_SRC (NUM_SRC),
         .IDX_W   (IDX_W),
         .SRV_W   (SRV_W),
         .PRIO_W  (PRIO_W)
      ) u_store (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (wr_en),
         .wr_op     (op),
         .wr_idx    (idx),
         .wr_server (req_server[SRV_W-1:0]),
         .wr_prio   (req_prio[PRIO_W-1:0]),
         .rd_idx    (idx),
         .rd_server (rd_server),
         .rd_prio   (rd_prio)
      );
   end else begin : g_no_unit
      assign rd_server = '0;
      assign rd_prio   = '0;
   end

   assign get_ok = (op == OP_GET) && (status == ST_OK);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_status <= ST_OK;
         rsp_nres   <= 2'd0;
         rsp_server <= '0;
         rsp_prio   <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_status <= status;
            rsp_nres   <= get_ok ? 2'd3 : 2'd1;
            rsp_server <= get_ok ? DATA_W'(rd_server) : '0;
            rsp_prio   <= get_ok ? rd_prio : '0;
         end else begin
            rsp_status <= ST_OK;
            rsp_nres   <= 2'd0;
            rsp_server <= '0;
            rsp_prio   <= '0;
         end
      end
   end

endmodule

// File: rtl/intsrc_cfg_chk.sv
module intsrc_cfg_chk #(
   parameter int unsigned IRQ_W       = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned CNT_W       = 4,
   parameter int unsigned PRIO_W      = 8,
   parameter int unsigned NUM_SRC     = 16,
   parameter int unsigned SRC_OFFSET  = 4096,
   parameter bit          SRC_PRESENT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [1:0]        req_op,
   input logic [CNT_W-1:0]  req_nargs,
   input logic [CNT_W-1:0]  req_nret,
   input logic [IRQ_W-1:0]  req_irq,
   input logic [DATA_W-1:0] req_prio,
   input logic              rsp_valid,
   input logic [1:0]        rsp_status,
   input logic [1:0]        rsp_nres
);

   localparam logic [IRQ_W:0]    WIN_HI   = (IRQ_W+1)'(64'(SRC_OFFSET) + 64'(NUM_SRC));
   localparam logic [DATA_W-1:0] PRIO_MAX = DATA_W'((64'd1 << PRIO_W) - 64'd1);

   logic get_wf;
   logic set_wf;
   assign get_wf = req_valid && req_op == 2'd1 && req_nargs == CNT_W'(1) && req_nret == CNT_W'(3);
   assign set_wf = req_valid && req_op == 2'd0 && req_nargs == CNT_W'(3) && req_nret == CNT_W'(1);

   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);  // R9
   AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);  // R9
   AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_status != 2'd3);  // R9
   AST_FAIL_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status != 2'd0) |-> rsp_nres == 2'd1);  // R6
   AST_GET_ARITY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 2'd1 && !(req_nargs == CNT_W'(1) && req_nret == CNT_W'(3)))
      |=> rsp_status == 2'd1);  // R8

   if (SRC_PRESENT) begin : g_unit_props
      AST_SET_PRIO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         (set_wf && req_prio > PRIO_MAX) |=> rsp_status == 2'd1);  // R3
      AST_IRQ_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
         (get_wf && {1'b0, req_irq} >= WIN_HI) |=> (rsp_status == 2'd1 && rsp_nres == 2'd1));  // R1
   end else begin : g_nounit_props
      AST_NO_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
         get_wf |=> rsp_status == 2'd2);  // R7
   end

endmodule

bind intsrc_cfg_table intsrc_cfg_chk #(
   .IRQ_W       (IRQ_W),
   .DATA_W      (DATA_W),
   .CNT_W       (CNT_W),
   .PRIO_W      (PRIO_W),
   .NUM_SRC     (NUM_SRC),
   .SRC_OFFSET  (SRC_OFFSET),
   .SRC_PRESENT (SRC_PRESENT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_op     (req_op),
   .req_nargs  (req_nargs),
   .req_nret   (req_nret),
   .req_irq    (req_irq),
   .req_prio   (req_prio),
   .rsp_valid  (rsp_valid),
   .rsp_status (rsp_status),
   .rsp_nres   (rsp_nres)
);

// File: tb/test_intsrc_cfg_table.sv
module test_intsrc_cfg_table;

   localparam int NSRC = 16;
   localparam int OFS  = 4096;
   localparam int NSRV = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_op = '0;
   logic [3:0]  req_nargs = '0;
   logic [3:0]  req_nret = '0;
   logic [31:0] req_irq = '0;
   logic [31:0] req_server = '0;
   logic [31:0] req_prio = '0;

   logic        rsp_valid, n_valid;
   logic [1:0]  rsp_status, n_status, rsp_nres, n_nres;
   logic [31:0] rsp_server, n_server;
   logic [7:0]  rsp_prio, n_prio;

   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;

   int m_srv [NSRC];
   int m_cur [NSRC];
   int m_sav [NSRC];

   always #2 clk = ~clk;

   intsrc_cfg_table #(.NUM_SRC(NSRC), .SRC_OFFSET(OFS), .NUM_SERVERS(NSRV)) i_intsrc_cfg_table (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_nargs(req_nargs), .req_nret(req_nret), .req_irq(req_irq),
      .req_server(req_server), .req_prio(req_prio),
      .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_nres(rsp_nres),
      .rsp_server(rsp_server), .rsp_prio(rsp_prio));

   intsrc_cfg_table #(.NUM_SRC(NSRC), .SRC_OFFSET(OFS), .NUM_SERVERS(NSRV), .SRC_PRESENT(1'b0)) i_intsrc_cfg_table_nounit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_nargs(req_nargs), .req_nret(req_nret), .req_irq(req_irq),
      .req_server(req_server), .req_prio(req_prio),
      .rsp_valid(n_valid), .rsp_status(n_status), .rsp_nres(n_nres),
      .rsp_server(n_server), .rsp_prio(n_prio));

   task automatic report(input string tag, input bit ok, input string got, input string exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: got %s expected %s", tag, got, exp);
      end
   endtask

   // one command; model computes expectation, response checked one cycle later
   task automatic cmd(input string tag, input int op, input int na, input int nr,
                      input longint irq, input longint srv, input longint pri);
      int st, nst, e_nres, e_srv, e_pri, li;
      bit arity;
      case (op)
         0: arity = (na == 3 && nr == 1);
         1: arity = (na == 1 && nr == 3);
         default: arity = (na == 1 && nr == 1);
      endcase
      li = int'(irq - OFS);
      if (!arity) st = 1;
      else if (irq < OFS || irq >= OFS + NSRC) st = 1;
      else if (op == 0 && (srv >= NSRV || pri > 255)) st = 1;
      else st = 0;
      nst = arity ? 2 : 1;
      e_nres = (op == 1 && st == 0) ? 3 : 1;
      e_srv = (op == 1 && st == 0) ? m_srv[li] : 0;
      e_pri = (op == 1 && st == 0) ? m_cur[li] : 0;
      if (st == 0) begin
         case (op)
            0: begin m_srv[li] = int'(srv); m_cur[li] = int'(pri); m_sav[li] = int'(pri); end
            2: begin m_sav[li] = m_cur[li]; m_cur[li] = 255; end
            3: begin m_cur[li] = m_sav[li]; end
            default: ;
         endcase
      end
      req_valid  = 1'b1;
      req_op     = 2'(op);
      req_nargs  = 4'(na);
      req_nret   = 4'(nr);
      req_irq    = 32'(irq);
      req_server = 32'(srv);
      req_prio   = 32'(pri);
      @(negedge clk);
      report(tag, rsp_valid === 1'b1 && rsp_status === 2'(st) && rsp_nres === 2'(e_nres)
                  && rsp_server === 32'(e_srv) && rsp_prio === 8'(e_pri),
             $sformatf("v%0b st%0d n%0d srv%0d pri%0h", rsp_valid, rsp_status, rsp_nres, rsp_server, rsp_prio),
             $sformatf("v1 st%0d n%0d srv%0d pri%0h", st, e_nres, e_srv, e_pri));
      report({tag, " R7 no-unit"}, n_valid === 1'b1 && n_status === 2'(nst) && n_nres === 2'd1,
             $sformatf("v%0b st%0d n%0d", n_valid, n_status, n_nres),
             $sformatf("v1 st%0d n1", nst));
      req_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         report("R9 idle", rsp_valid === 1'b0 && n_valid === 1'b0,
                $sformatf("%0b/%0b", rsp_valid, n_valid), "0/0");
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      for (int i = 0; i < NSRC; i++) begin m_srv[i] = 0; m_cur[i] = 255; m_sav[i] = 255; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(2);                                          // R9 reset state, no pulse
      cmd("R10 reset entry0",  1, 1, 3, OFS,        0, 0);
      cmd("R10 reset last",    1, 1, 3, OFS+NSRC-1, 0, 0);
      cmd("R5 R10 on after reset", 3, 1, 1, OFS+2,  0, 0);
      cmd("R10 saved FF",      1, 1, 3, OFS+2,      0, 0);
      // R2 / R1 set and readback at window edges, back-to-back
      cmd("R2 set first",      0, 3, 1, OFS,        3, 5);
      cmd("R1 R6 get first",   1, 1, 3, OFS,        0, 0);
      cmd("R2 set last",       0, 3, 1, OFS+NSRC-1, 1, 0);
      cmd("R1 R6 get last",    1, 1, 3, OFS+NSRC-1, 0, 0);
      cmd("R2 set prio FF",    0, 3, 1, OFS+7,      2, 255);
      cmd("R2 get prio FF",    1, 1, 3, OFS+7,      0, 0);
      idle(1);
      // R1 out of window
      cmd("R1 set below",      0, 3, 1, OFS-1,      1, 9);
      cmd("R1 R6 get above",   1, 1, 3, OFS+NSRC,   0, 0);
      cmd("R1 off above",      2, 1, 1, OFS+NSRC+40, 0, 0);
      cmd("R1 get zero",       1, 1, 3, 0,          0, 0);
      // R3 bad set arguments leave entry alone
      cmd("R3 server limit",   0, 3, 1, OFS,        NSRV, 7);
      cmd("R3 prio 0x100",     0, 3, 1, OFS,        0, 256);
      cmd("R3 huge server",    0, 3, 1, OFS,        32'hFFFF_FFFF, 1);
      cmd("R3 unchanged",      1, 1, 3, OFS,        0, 0);
      // R4 / R5 masking
      cmd("R4 off",            2, 1, 1, OFS,        0, 0);
      cmd("R4 get masked",     1, 1, 3, OFS,        0, 0);
      cmd("R5 on",             3, 1, 1, OFS,        0, 0);
      cmd("R5 get restored",   1, 1, 3, OFS,        0, 0);
      cmd("R4 off once",       2, 1, 1, OFS,        0, 0);
      cmd("R4 off twice",      2, 1, 1, OFS,        0, 0);
      cmd("R4 R5 on after two",3, 1, 1, OFS,        0, 0);
      cmd("R4 double masked",  1, 1, 3, OFS,        0, 0);
      cmd("R5 set again",      0, 3, 1, OFS+9,      3, 8'h40);
      cmd("R5 on keeps",       3, 1, 1, OFS+9,      0, 0);
      cmd("R5 get kept",       1, 1, 3, OFS+9,      0, 0);
      idle(2);
      // R8 arity mismatches
      cmd("R8 set 2 args",     0, 2, 1, OFS+3,      1, 1);
      cmd("R8 get 1 ret",      1, 1, 1, OFS+3,      0, 0);
      cmd("R8 off 2 ret",      2, 1, 2, OFS+NSRC-1, 0, 0);
      cmd("R8 on 0 args",      3, 0, 1, OFS+NSRC-1, 0, 0);
      cmd("R8 set as get",     0, 1, 3, OFS+3,      1, 1);
      cmd("R8 entry intact",   1, 1, 3, OFS+3,      0, 0);
      cmd("R8 last intact",    1, 1, 3, OFS+NSRC-1, 0, 0);
      // R9 sweep: set every entry then read back
      for (int i = 0; i < NSRC; i++) cmd("R9 R2 sweep set", 0, 3, 1, OFS+i, i % NSRV, (i*37) & 255);
      for (int i = 0; i < NSRC; i++) cmd("R9 R6 sweep get", 1, 1, 3, OFS+i, 0, 0);
      idle(2);
      finish_run();
   end

endmodule